// File: doc/BRIEF.md
# 64-bit Memory Read Error Correction Path

This block sits on the read side of a memory controller. It takes a 64-bit data word and its 8 stored checkbits from the memory bus. It rebuilds the checkbits from the data it received and compares them with the stored ones to form an 8-bit syndrome. From the syndrome it repairs any single flipped bit, whether that bit is in the data or in the checkbits, and it raises a flag when the word holds more errors than it can repair.

The block has two capture stages, each with its own hold control. An input stage holds the raw word and its checkbits. An output stage holds the corrected word and its two flags on their way to the system bus. The corrected data and checkbits are also driven, unregistered, on a write-back path so that a scrubber can return the repaired word to memory.

The code is a single-error-correcting, double-error-detecting Hamming code. Seven checkbits cover codeword positions 1 to 71. An eighth checkbit gives the parity of the whole word.

Top module: `ecc_read_path`

## Requirements
- R1: While reset is asserted and after it is released, `sys_data` is zero and `sys_single` and `sys_multi` are low. The input stage also clears to zero, which is a clean all-zero codeword.
- R2: Data bit i sits at the i-th codeword position, counted upward from 3, that is not a power of two (data bit 0 at 3, data bit 63 at 71). For j below 7, checkbit j is the XOR of the data bits whose position has bit j set. Checkbit 7 is the XOR of all 64 data bits and checkbits 0 to 6. A word encoded this way passes through with `wb_data` and `wb_check` unchanged and both flags low.
- R3: A word with exactly one flipped bit, among the 64 data bits or the 8 checkbits, is restored on `wb_data` and `wb_check`. The single flag is raised and the multiple flag stays low. At most one bit is ever inverted.
- R4: A word with exactly two flipped bits raises the multiple flag and leaves the single flag low.
- R5: When the overall parity fails but the 7-bit syndrome names a position above 71, the multiple flag is raised and the single flag stays low.
- R6: The single and multiple flags are never high together.
- R7: While `in_hold` is high at a clock edge, the input stage keeps its word, so new values on `mem_data` and `mem_chk` do not change `wb_data` or `wb_check`.
- R8: While `out_hold` is high at a clock edge, `sys_data`, `sys_single` and `sys_multi` keep their values.
- R9: With both holds low, a word driven on the memory bus appears on the write-back outputs after one clock edge and on the system outputs after two.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_data | input | 64 | Data word read from memory |
| mem_chk | input | 8 | Checkbits read from memory |
| in_hold | input | 1 | High: the input stage keeps its word |
| out_hold | input | 1 | High: the system-side stage keeps its word and flags |
| sys_data | output | 64 | Corrected data toward the system bus |
| sys_single | output | 1 | A single-bit error was corrected in `sys_data` |
| sys_multi | output | 1 | Uncorrectable error; `sys_data` is not valid |
| wb_data | output | 64 | Corrected data on the write-back path |
| wb_check | output | 8 | Corrected checkbits on the write-back path |

## Verification
The case hardest to reach from the ports is an odd-weight error whose syndrome points past position 71. Single-bit and double-bit sweeps never produce it. The bench reaches it on purpose by flipping checkbit 6, checkbit 3 and data bit 0. Their positions 64, 8 and 3 XOR to 75, and the three flips together fail the overall parity. The two holds are exercised by changing the memory bus while a hold is asserted. The outputs are then compared with the word captured before the change.

// File: rtl/ecc_rd_pkg.sv
package ecc_rd_pkg;

  // Codeword position of data bit idx: the idx-th non-power-of-two from 3 upward.
  function automatic int unsigned ecc_data_pos(int unsigned idx);
    int unsigned cnt;
    int unsigned res;
    bit          found;
    cnt   = 0;
    res   = 0;
    found = 1'b0;
    for (int unsigned p = 1; p < 1024; p++) begin
      if (!found && ((p & (p - 1)) != 0)) begin
        if (cnt == idx) begin
          res   = p;
          found = 1'b1;
        end
        cnt++;
      end
    end
    return res;
  endfunction

  // Number of position checkbits needed to cover dw data bits.
  function automatic int unsigned ecc_need_pchk(int unsigned dw);
    int unsigned res;
    res = 0;
    for (int unsigned p = 20; p >= 1; p--) begin
      if (((1 << p) - p - 1) >= dw) res = p;
    end
    return res;
  endfunction

endpackage

// File: rtl/ecc_hold_reg.sv
module ecc_hold_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (!hold) q <= d;
  end
endmodule

// File: rtl/ecc_chkgen.sv
module ecc_chkgen
  import ecc_rd_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned P_W    = 7
) (
  input  logic [DATA_W-1:0] data,
  output logic [P_W-1:0]    pchk
);
  function automatic logic [DATA_W-1:0] col_mask(int unsigned j);
    logic [DATA_W-1:0] m;
    for (int unsigned i = 0; i < DATA_W; i++) begin
      m[i] = (((ecc_data_pos(i) >> j) & 32'd1) != 32'd0);
    end
    return m;
  endfunction

  for (genvar j = 0; j < P_W; j++) begin : g_col
    localparam logic [DATA_W-1:0] MASK = col_mask(j);
    assign pchk[j] = ^(data & MASK);
  end
endmodule

// File: rtl/ecc_syndrome.sv
module ecc_syndrome #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned P_W    = 7
) (
  input  logic [DATA_W-1:0] data,
  input  logic [P_W:0]      chk,
  output logic [P_W-1:0]    syn,
  output logic              syn_all
);
  logic [P_W-1:0] regen;

  ecc_chkgen #(.DATA_W(DATA_W), .P_W(P_W)) i_gen (
    .data (data),
    .pchk (regen)
  );

  assign syn     = regen ^ chk[P_W-1:0];
  assign syn_all = (^data) ^ (^chk);
endmodule

// File: rtl/ecc_correct.sv
module ecc_correct
  import ecc_rd_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned P_W    = 7
) (
  input  logic [DATA_W-1:0] data,
  input  logic [P_W:0]      chk,
  input  logic [P_W-1:0]    syn,
  input  logic              syn_all,
  output logic [DATA_W-1:0] flip_d,
  output logic [P_W:0]      flip_c,
  output logic [DATA_W-1:0] cdata,
  output logic [P_W:0]      cchk,
  output logic              single,
  output logic              multi
);
  localparam logic [P_W-1:0] MAXP = P_W'(ecc_data_pos(DATA_W - 1));

  logic corr_en;
  assign corr_en = syn_all && (syn <= MAXP);

  for (genvar i = 0; i < DATA_W; i++) begin : g_dbit
    localparam logic [P_W-1:0] POS = P_W'(ecc_data_pos(i));
    assign flip_d[i] = corr_en && (syn == POS);
  end

  for (genvar j = 0; j < P_W; j++) begin : g_cbit
    localparam logic [P_W-1:0] POS = P_W'(1 << j);
    assign flip_c[j] = corr_en && (syn == POS);
  end
  assign flip_c[P_W] = corr_en && (syn == '0);

  assign cdata  = data ^ flip_d;
  assign cchk   = chk ^ flip_c;
  assign single = corr_en;
  assign multi  = (!syn_all && (syn != '0)) || (syn_all && (syn > MAXP));
endmodule

// File: rtl/ecc_read_path.sv
module ecc_read_path
  import ecc_rd_pkg::*;
#(
  parameter  int unsigned DATA_W = 64,
  localparam int unsigned P_W    = ecc_need_pchk(DATA_W),
  localparam int unsigned CHK_W  = P_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] mem_data,
  input  logic [CHK_W-1:0]  mem_chk,
  input  logic              in_hold,
  input  logic              out_hold,
  output logic [DATA_W-1:0] sys_data,
  output logic              sys_single,
  output logic              sys_multi,
  output logic [DATA_W-1:0] wb_data,
  output logic [CHK_W-1:0]  wb_check
);
  localparam int unsigned IN_W  = DATA_W + CHK_W;
  localparam int unsigned OUT_W = DATA_W + 2;

  // Named internal events, observed by the bound checker.
  logic [DATA_W-1:0] rx_data;
  logic [CHK_W-1:0]  rx_chk;
  logic [P_W-1:0]    syn_w;
  logic              syn_all_w;
  logic [DATA_W-1:0] flip_d;
  logic [CHK_W-1:0]  flip_c;
  logic              dec_single;
  logic              dec_multi;

  ecc_hold_reg #(.W(IN_W)) i_in_stage (
    .clk   (clk),
    .rst_n (rst_n),
    .hold  (in_hold),
    .d     ({mem_chk, mem_data}),
    .q     ({rx_chk, rx_data})
  );

  ecc_syndrome #(.DATA_W(DATA_W), .P_W(P_W)) i_syn (
    .data    (rx_data),
    .chk     (rx_chk),
    .syn     (syn_w),
    .syn_all (syn_all_w)
  );

  ecc_correct #(.DATA_W(DATA_W), .P_W(P_W)) i_fix (
    .data    (rx_data),
    .chk     (rx_chk),
    .syn     (syn_w),
    .syn_all (syn_all_w),
    .flip_d  (flip_d),
    .flip_c  (flip_c),
    .cdata   (wb_data),
    .cchk    (wb_check),
    .single  (dec_single),
    .multi   (dec_multi)
  );

  ecc_hold_reg #(.W(OUT_W)) i_out_stage (
    .clk   (clk),
    .rst_n (rst_n),
    .hold  (out_hold),
    .d     ({dec_multi, dec_single, wb_data}),
    .q     ({sys_multi, sys_single, sys_data})
  );
endmodule

// File: rtl/ecc_read_path_chk.sv
module ecc_read_path_chk #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned CHK_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_hold,
  input logic              out_hold,
  input logic [DATA_W-1:0] rx_data,
  input logic [CHK_W-1:0]  rx_chk,
  input logic [CHK_W-2:0]  syn_w,
  input logic              syn_all_w,
  input logic [DATA_W-1:0] flip_d,
  input logic [CHK_W-1:0]  flip_c,
  input logic              dec_single,
  input logic              dec_multi,
  input logic [DATA_W-1:0] wb_data,
  input logic [CHK_W-1:0]  wb_check,
  input logic [DATA_W-1:0] sys_data,
  input logic              sys_single,
  input logic              sys_multi
);
  // R2
  clean_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (syn_w == '0 && !syn_all_w) |->
      (wb_data == rx_data && wb_check == rx_chk && !dec_single && !dec_multi));

  // R3
  one_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flip_d, flip_c}));

  // R3
  flip_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones({flip_d, flip_c}) == 1) == dec_single);

  // R6
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dec_single && dec_multi) && !(sys_single && sys_multi));

  // R7
  in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_hold |=> ($stable(rx_data) && $stable(rx_chk)));

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_hold |=> ($stable(sys_data) && $stable(sys_single) && $stable(sys_multi)));

  // R9
  out_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_hold |=> (sys_data == $past(wb_data) && sys_single == $past(dec_single)
                   && sys_multi == $past(dec_multi)));
endmodule

bind ecc_read_path ecc_read_path_chk #(.DATA_W(DATA_W), .CHK_W(CHK_W)) i_chk (.*);

// File: tb/test_ecc_read_path.sv
module test_ecc_read_path;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 64;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] mem_data = '0;
  logic [CW-1:0] mem_chk = '0;
  logic          in_hold = 1'b0;
  logic          out_hold = 1'b0;
  logic [DW-1:0] sys_data;
  logic          sys_single;
  logic          sys_multi;
  logic [DW-1:0] wb_data;
  logic [CW-1:0] wb_check;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int pos_tab [DW];

  always #(CLK_PERIOD / 2) clk = ~clk;

  ecc_read_path i_ecc_read_path (
    .clk(clk), .rst_n(rst_n), .mem_data(mem_data), .mem_chk(mem_chk),
    .in_hold(in_hold), .out_hold(out_hold), .sys_data(sys_data),
    .sys_single(sys_single), .sys_multi(sys_multi),
    .wb_data(wb_data), .wb_check(wb_check)
  );

  task automatic check(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bench encoder, restated from R2: skip positions whose popcount is one.
  function automatic logic [CW-1:0] encode(logic [DW-1:0] d);
    logic [CW-1:0] c;
    c = '0;
    for (int i = 0; i < DW; i++)
      for (int j = 0; j < CW - 1; j++)
        if (pos_tab[i][j]) c[j] ^= d[i];
    c[CW-1] = (^d) ^ (^c[CW-2:0]);
    return c;
  endfunction

  // Drive a word, check write-back after one edge and system side after two (R9).
  task automatic run_word(logic [DW-1:0] d, logic [CW-1:0] c,
                          logic [DW-1:0] exp_d, logic [CW-1:0] exp_c,
                          bit exp_s, bit exp_m, string req);
    @(negedge clk);
    mem_data = d;
    mem_chk  = c;
    @(negedge clk);
    if (!exp_m) begin
      check(wb_data == exp_d, {req, " wb_data"}, wb_data, exp_d);
      check(wb_check == exp_c, {req, " wb_check"}, DW'(wb_check), DW'(exp_c));
    end
    @(negedge clk);
    if (!exp_m) check(sys_data == exp_d, {req, " sys_data R9"}, sys_data, exp_d);
    check(sys_single == exp_s, {req, " single flag"}, DW'(sys_single), DW'(exp_s));
    check(sys_multi == exp_m, {req, " multi flag"}, DW'(sys_multi), DW'(exp_m));
    check(!(sys_single && sys_multi), "R6 exclusive flags", DW'({sys_single, sys_multi}), '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] words [4];
    logic [DW-1:0] a, b;
    logic [CW-1:0] ca, cb;
    int p;
    p = 1;
    for (int i = 0; i < DW; i++) begin
      while ($countones(p) == 1) p++;
      pos_tab[i] = p;
      p++;
    end
    words[0] = 64'h0000_0000_0000_0000;
    words[1] = 64'hFFFF_FFFF_FFFF_FFFF;
    words[2] = 64'hA5C3_0F1E_9B27_64D8;
    words[3] = 64'h0123_4567_89AB_CDEF;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(sys_data == '0, "R1 sys_data in reset", sys_data, '0);
    check(!sys_single && !sys_multi, "R1 flags in reset", DW'({sys_single, sys_multi}), '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(sys_data == '0 && !sys_single && !sys_multi, "R1 after release",
          sys_data, '0);
    check(wb_data == '0 && wb_check == '0, "R1 input stage clear", wb_data, '0);

    // R2: clean words
    for (int w = 0; w < 4; w++) begin
      ca = encode(words[w]);
      run_word(words[w], ca, words[w], ca, 1'b0, 1'b0, "R2 clean");
    end
    for (int k = 0; k < DW; k++) begin
      a = DW'(1) << k;
      ca = encode(a);
      run_word(a, ca, a, ca, 1'b0, 1'b0, "R2 walking one");
    end

    // R3: every single-bit error on each word
    for (int w = 0; w < 4; w++) begin
      ca = encode(words[w]);
      for (int k = 0; k < DW + CW; k++) begin
        logic [DW+CW-1:0] cw;
        cw = {ca, words[w]};
        cw[k] = ~cw[k];
        run_word(cw[DW-1:0], cw[DW+CW-1:DW], words[w], ca, 1'b1, 1'b0, "R3 single");
      end
    end

    // R4: double errors on adjacent and distant pairs
    for (int w = 2; w < 4; w++) begin
      ca = encode(words[w]);
      for (int k = 0; k < DW + CW - 1; k++) begin
        logic [DW+CW-1:0] cw;
        cw = {ca, words[w]};
        cw[k] = ~cw[k];
        cw[k + 1] = ~cw[k + 1];
        run_word(cw[DW-1:0], cw[DW+CW-1:DW], '0, '0, 1'b0, 1'b1, "R4 double adj");
        cw = {ca, words[w]};
        cw[k] = ~cw[k];
        cw[(k + 37) % (DW + CW)] = ~cw[(k + 37) % (DW + CW)];
        run_word(cw[DW-1:0], cw[DW+CW-1:DW], '0, '0, 1'b0, 1'b1, "R4 double far");
      end
    end

    // R5: checkbit 6 (pos 64), checkbit 3 (pos 8), data 0 (pos 3) -> syndrome 75
    ca = encode(words[2]);
    a = words[2] ^ 64'h1;
    cb = ca ^ 8'h48;
    run_word(a, cb, '0, '0, 1'b0, 1'b1, "R5 syndrome beyond 71");

    // R7: input hold ignores new bus values
    a = words[3];  ca = encode(a);
    b = words[2];  cb = encode(b);
    run_word(a, ca, a, ca, 1'b0, 1'b0, "R7 setup");
    @(negedge clk);
    in_hold = 1'b1;
    mem_data = b;
    mem_chk = cb ^ 8'h01;
    @(negedge clk);
    check(wb_data == a, "R7 wb_data held", wb_data, a);
    check(wb_check == ca, "R7 wb_check held", DW'(wb_check), DW'(ca));
    @(negedge clk);
    check(sys_data == a && !sys_single, "R7 sys side unchanged", sys_data, a);
    in_hold = 1'b0;

    // R8: output hold keeps system side while write-back moves on
    @(negedge clk);
    out_hold = 1'b1;
    mem_data = b;
    mem_chk = cb ^ 8'h01;
    @(negedge clk);
    check(wb_data == b && wb_check == cb, "R8 wb follows new word", wb_data, b);
    @(negedge clk);
    check(sys_data == a, "R8 sys_data held", sys_data, a);
    check(!sys_single && !sys_multi, "R8 flags held", DW'({sys_single, sys_multi}), '0);
    out_hold = 1'b0;
    @(negedge clk);
    check(sys_data == b && sys_single, "R8 release shows corrected word", sys_data, b);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule